// File: doc/BRIEF.md
# TDM Time-Slot Selector with Per-Bit Mask

This block sits on a serial time-division highway and carries one channel in each direction. A frame-sync pulse resets its position counter. A configured slot number then picks one 8-bit slot out of up to 64 slots in the frame. An 8-bit mask picks which bit positions inside that slot belong to the channel, so the channel can run at any multiple of 8 kbit/s, from one bit per frame up to the whole octet.

On the receive side, each enabled bit on the highway comes out as a serial bit with a one-period valid strobe. On the transmit side, the block pulls bits from a valid/ready bitstream source. It drives them onto the line only in the enabled positions and asserts a pad output-enable there. Outside those positions the enable is low and the line is left free for other devices. The whole block is clocked by the highway bit clock.

Top module: `tdm_slot_sel`

## Requirements
- R1: A high `fs_i` at a rising edge of `clk_i` makes the bit period that starts at that edge slot 0, bit 0. Without a frame sync, the position advances by one each period and wraps after the last bit of slot 63.
- R2: Only bit periods of the slot whose number equals the active slot setting can carry channel data.
- R3: Mask bit 7 stands for the first bit of the slot on the line and mask bit 0 for the last. A bit period carries data exactly when its mask bit is 1. Every mask from one to eight set bits is honoured.
- R4: In every enabled period, `rx_i` is sampled at the falling edge of `clk_i`. At that edge `rx_bit_o` takes the sampled value and `rx_vld_o` goes high for one period. In a period that is not enabled, `rx_vld_o` is low.
- R5: In every enabled period, `tx_oe_o` is high from the rising edge that starts the period. `tx_o` then carries the source bit. In every other period, `tx_oe_o` is low.
- R6: `tx_rdy_o` is high during the period before an enabled period. A source bit is consumed only at a rising edge where both `tx_rdy_o` and `tx_vld_i` are high.
- R7: If `tx_vld_i` is low when an enabled period starts, the block drives logic 1 in that period and consumes nothing.
- R8: While the active mask is all zeros, no receive strobe occurs, `tx_oe_o` stays low and no source bit is consumed.
- R9: New values on `slot_i` and `mask_i` become active only at a frame-sync edge. After reset and before the first frame sync, the channel is disabled.
- R10: During reset, `rx_vld_o`, `tx_oe_o` and `tx_rdy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Highway bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync, sampled on the rising edge |
| slot_i | input | 6 | Requested slot number |
| mask_i | input | 8 | Requested bit mask, bit 7 = first bit on the line |
| rx_i | input | 1 | Highway receive data |
| rx_bit_o | output | 1 | Extracted receive bit |
| rx_vld_o | output | 1 | Receive bit strobe |
| tx_bit_i | input | 1 | Source transmit bit |
| tx_vld_i | input | 1 | Source bit available |
| tx_rdy_o | output | 1 | Source bit is taken at the next rising edge when valid |
| tx_o | output | 1 | Highway transmit data |
| tx_oe_o | output | 1 | Transmit pad output enable |

## Verification
The bench targets several corner cases, and each has a clear failure mode. It uses slot 63 with only the last mask bit set; a design with an off-by-one in the counter or a reversed mask would strobe in the wrong period, or in a different slot entirely. It shortens a frame so that frame sync lands in the middle of the selected slot; a design that does not restart its counter would keep the old alignment. It changes the configuration in the middle of a frame; a design without the frame-sync shadow would switch slots early. A source that starves entirely or stalls at random exposes a design that shifts stale data instead of driving ones, or that consumes bits it never drove. A zero mask has to stay silent on all outputs.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  localparam int unsigned DEF_SLOT_W    = 6;
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam logic        UNDERRUN_FILL = 1'b1;
endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_sel_pkg::*;
#(
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned POS_W     = SLOT_W + $clog2(SLOT_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fs_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  output logic [POS_W-1:0]     pos_nxt_o,
  output logic [SLOT_W-1:0]    slot_nxt_o,
  output logic [SLOT_BITS-1:0] mask_nxt_o,
  output logic [POS_W-1:0]     pos_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [SLOT_BITS-1:0] mask_o
);
  logic [POS_W-1:0]     pos_q;
  logic [SLOT_W-1:0]    slot_q;
  logic [SLOT_BITS-1:0] mask_q;

  always_comb begin
    pos_nxt_o  = fs_i ? '0 : pos_q + 1'b1;
    slot_nxt_o = fs_i ? slot_i : slot_q;
    mask_nxt_o = fs_i ? mask_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      slot_q <= '0;
      mask_q <= '0;   // channel off until first frame sync
    end else begin
      pos_q  <= pos_nxt_o;
      slot_q <= slot_nxt_o;
      mask_q <= mask_nxt_o;
    end
  end

  assign pos_o  = pos_q;
  assign slot_o = slot_q;
  assign mask_o = mask_q;

  // R1
  pos_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |=> pos_q == '0);
  // R1
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_i |=> pos_q == $past(pos_q) + 1'b1);
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_i |=> $stable(mask_q) && $stable(slot_q));
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
  import tdm_sel_pkg::*;
#(
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
  parameter int unsigned POS_W     = SLOT_W + $clog2(SLOT_BITS)
) (
  input  logic [POS_W-1:0]     pos_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  output logic                 en_o
);
  localparam int unsigned BIT_W = $clog2(SLOT_BITS);

  logic                 slot_hit;
  logic [BIT_W-1:0]     bit_idx;
  logic [SLOT_BITS-1:0] bit_sel;

  assign slot_hit = (pos_i[POS_W-1:BIT_W] == slot_i);
  assign bit_idx  = pos_i[BIT_W-1:0];

  // line order: first bit of slot maps to mask MSB
  for (genvar b = 0; b < SLOT_BITS; b++) begin : g_bit
    assign bit_sel[b] = (bit_idx == BIT_W'(b)) && mask_i[SLOT_BITS-1-b];
  end

  assign en_o = slot_hit && (|bit_sel);
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_nxt_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic rdy_o,
  output logic tx_o,
  output logic oe_o
);
  logic tx_q;
  logic oe_q;

  assign rdy_o = en_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= UNDERRUN_FILL;
      oe_q <= 1'b0;
    end else begin
      oe_q <= en_nxt_i;
      if (en_nxt_i) tx_q <= vld_i ? bit_i : UNDERRUN_FILL;
    end
  end

  assign tx_o = tx_q;
  assign oe_o = oe_q;

  // R7
  underrun_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_nxt_i && !vld_i |=> oe_o && tx_o);
  // R5
  tx_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_nxt_i && vld_i |=> oe_o && (tx_o == $past(bit_i)));
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rx_i,
  output logic bit_o,
  output logic vld_o
);
  logic bit_q;
  logic vld_q;

  // sampled mid-period on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en_i;
      if (en_i) bit_q <= rx_i;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  // R4
  rx_capture_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    en_i |=> vld_o && (bit_o == $past(rx_i)));
endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel
  import tdm_sel_pkg::*;
#(
  parameter int unsigned SLOT_W    = DEF_SLOT_W,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fs_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [SLOT_BITS-1:0] mask_i,
  input  logic                 rx_i,
  output logic                 rx_bit_o,
  output logic                 rx_vld_o,
  input  logic                 tx_bit_i,
  input  logic                 tx_vld_i,
  output logic                 tx_rdy_o,
  output logic                 tx_o,
  output logic                 tx_oe_o
);
  localparam int unsigned POS_W = SLOT_W + $clog2(SLOT_BITS);

  logic [POS_W-1:0]     pos_nxt, pos_cur;
  logic [SLOT_W-1:0]    slot_nxt, slot_act;
  logic [SLOT_BITS-1:0] mask_nxt, mask_act;
  logic                 en_nxt, en_cur;

  tdm_frame_ctr #(.SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fs_i       (fs_i),
    .slot_i     (slot_i),
    .mask_i     (mask_i),
    .pos_nxt_o  (pos_nxt),
    .slot_nxt_o (slot_nxt),
    .mask_nxt_o (mask_nxt),
    .pos_o      (pos_cur),
    .slot_o     (slot_act),
    .mask_o     (mask_act)
  );

  // look-ahead decode for the period about to start (tx side)
  tdm_slot_decode #(.SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_dec_nxt (
    .pos_i  (pos_nxt),
    .slot_i (slot_nxt),
    .mask_i (mask_nxt),
    .en_o   (en_nxt)
  );

  // decode for the running period (rx side)
  tdm_slot_decode #(.SLOT_W(SLOT_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_dec_cur (
    .pos_i  (pos_cur),
    .slot_i (slot_act),
    .mask_i (mask_act),
    .en_o   (en_cur)
  );

  tdm_tx_lane u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_nxt_i (en_nxt),
    .vld_i    (tx_vld_i),
    .bit_i    (tx_bit_i),
    .rdy_o    (tx_rdy_o),
    .tx_o     (tx_o),
    .oe_o     (tx_oe_o)
  );

  tdm_rx_lane u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_cur),
    .rx_i   (rx_i),
    .bit_o  (rx_bit_o),
    .vld_o  (rx_vld_o)
  );

  // R8
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_act == '0) |-> !tx_oe_o && !rx_vld_o);
  // R2
  slot_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> (pos_cur[POS_W-1:$clog2(SLOT_BITS)] == slot_act));
endmodule

// File: tb/sim_tdm_slot_sel.sv
module sim_tdm_slot_sel;
  localparam int CLK_PERIOD = 20;
  localparam int FRAME      = 512;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fs_i = 1'b0;
  logic [5:0] slot_i = '0;
  logic [7:0] mask_i = '0;
  logic       rx_i = 1'b0;
  logic       tx_bit_i = 1'b0;
  logic       tx_vld_i = 1'b0;
  logic       rx_bit_o, rx_vld_o, tx_rdy_o, tx_o, tx_oe_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tdm_slot_sel u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_i(fs_i), .slot_i(slot_i), .mask_i(mask_i),
    .rx_i(rx_i), .rx_bit_o(rx_bit_o), .rx_vld_o(rx_vld_o),
    .tx_bit_i(tx_bit_i), .tx_vld_i(tx_vld_i), .tx_rdy_o(tx_rdy_o),
    .tx_o(tx_o), .tx_oe_o(tx_oe_o)
  );

  int   n_vec = 0;
  int   n_err = 0;
  int   src_idx = 0;
  int   vld_mode = 0;   // 0 always, 1 random, 2 never
  logic [5:0] act_slot = '0;
  logic [7:0] act_mask = '0;
  bit   rxq[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit src_bit(input int i);
    return i[0] ^ i[2] ^ i[5];
  endfunction

  function automatic bit exp_en(input int p);
    if (p < 0) return 1'b0;
    return (p / 8 == int'(act_slot)) && act_mask[7 - (p % 8)];
  endfunction

  // driver: one bit period, position p of the bench's frame
  task automatic do_period(input int p, input bit fs);
    bit en, vld, ev, rb;
    fs_i = fs;
    if (fs) begin act_slot = slot_i; act_mask = mask_i; end
    en  = exp_en(p);
    vld = (vld_mode == 0) ? 1'b1 : (vld_mode == 2) ? 1'b0 : 1'($urandom % 2);
    tx_vld_i = vld;
    tx_bit_i = src_bit(src_idx);
    #1;
    chk(tx_rdy_o == en, "R6 tx_rdy_o", int'(tx_rdy_o), int'(en));
    ev = vld ? tx_bit_i : 1'b1;
    if (en && vld) src_idx++;
    @(posedge clk_i); #1;
    fs_i = 1'b0;
    chk(tx_oe_o == en, "R5 tx_oe_o", int'(tx_oe_o), int'(en));
    if (en) chk(tx_o == ev, vld ? "R5 tx_o" : "R7 tx_o underrun", int'(tx_o), int'(ev));
    rb = 1'($urandom % 2);
    rx_i = rb;
    if (en) rxq.push_back(rb);
    @(negedge clk_i); #1;
    chk(rx_vld_o == en, "R4 rx_vld_o", int'(rx_vld_o), int'(en));
  endtask

  // frame of len periods; config inputs change at period chg_at (-1: none)
  task automatic frame(input int len, input int chg_at, input logic [5:0] ns, input logic [7:0] nm);
    for (int p = 0; p < len; p++) begin
      if (p == chg_at) begin slot_i = ns; mask_i = nm; end
      do_period(p, p == 0);
    end
  endtask

  // monitor: scoreboard pop on every receive strobe
  initial begin
    forever begin
      @(negedge clk_i); #2;
      if (rst_ni && rx_vld_o) begin
        if (rxq.size() == 0) chk(1'b0, "R4 unexpected rx strobe", 1, 0);
        else begin
          bit e;
          e = rxq.pop_front();
          chk(rx_bit_o == e, "R4 rx_bit_o", int'(rx_bit_o), int'(e));
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R10: reset state
    slot_i = 6'd0; mask_i = 8'hFF;
    repeat (3) @(posedge clk_i);
    #1;
    chk(rx_vld_o == 1'b0, "R10 rx_vld_o", int'(rx_vld_o), 0);
    chk(tx_oe_o == 1'b0, "R10 tx_oe_o", int'(tx_oe_o), 0);
    chk(tx_rdy_o == 1'b0, "R10 tx_rdy_o", int'(tx_rdy_o), 0);
    @(negedge clk_i); rst_ni = 1'b1; #1;

    // R9: no frame sync yet -> channel disabled despite mask_i
    for (int i = 0; i < 12; i++) do_period(-1, 1'b0);

    // R2 R3: full octet in slot 0
    frame(FRAME, -1, 0, 0);
    // R3: D-channel, first two bits, random stalls
    slot_i = 6'd5; mask_i = 8'hC0; vld_mode = 1;
    frame(FRAME, -1, 0, 0);
    // R1 R3: last bit of last slot
    slot_i = 6'd63; mask_i = 8'h01; vld_mode = 0;
    frame(FRAME, -1, 0, 0);
    frame(FRAME, -1, 0, 0);
    // R7: starved source on alternating bits
    slot_i = 6'd17; mask_i = 8'h55; vld_mode = 2;
    frame(FRAME, -1, 0, 0);
    // R3: seven bits
    slot_i = 6'd33; mask_i = 8'hFE; vld_mode = 1;
    frame(FRAME, -1, 0, 0);
    // R8: zero mask
    slot_i = 6'd9; mask_i = 8'h00; vld_mode = 0;
    frame(FRAME, -1, 0, 0);
    // R9: mid-frame change held until next frame sync
    slot_i = 6'd20; mask_i = 8'hAA;
    frame(FRAME, 100, 6'd40, 8'hF0);
    frame(FRAME, -1, 0, 0);
    // R1: frame sync arrives inside the selected slot
    slot_i = 6'd3; mask_i = 8'hFF;
    frame(28, -1, 0, 0);
    frame(FRAME, -1, 0, 0);

    repeat (2) @(negedge clk_i);
    #3;
    chk(rxq.size() == 0, "R4 scoreboard drained", rxq.size(), 0);
    finish_run();
  end
endmodule